// File: doc/BRIEF.md
# Pin I/O Port with Per-Pin Interrupt Detection

This block is a word-addressed general-purpose I/O port for sixteen pins. Software sets a drive value and a drive enable for each pin and reads back what the pins show. It can also pick, for each pin, a rule that turns pin activity into a pending interrupt. Pads are modelled as an output-value vector and a separate output-enable vector, so no tri-state logic sits inside the block. Every pin input passes through a two-flop synchroniser before it is read or examined.

Each pin has a 3-bit style field. The fields for pins 0 to 7 sit in the first style register and the fields for pins 8 to 15 sit in the second. A style can detect a high level, a low level, a rising edge, a falling edge, or either edge. When a pin meets its rule, its sticky pending bit is set. Software clears a pending bit by writing a 1 to it. One interrupt line stays high while any pending bit is set. Two more registers give software plain storage for clock-output and debounce settings that the block does not use.

The bus carries only full 32-bit accesses and uses a 3-bit word index, which is the byte offset divided by four. Reads are combinational from the index.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, pad_out, pad_oe and irq are 0, and every register reads 0. A style field of 0 means active-high level.
- R2: Word 0 (byte 0x00) holds the drive values and word 1 (byte 0x04) holds the drive enables. Bit n drives pad_out[n] and pad_oe[n]. Bits 31:16 read as 0.
- R3: Word 2 (byte 0x08) returns the synchronised pad value two clock edges after a pad changes. A pin whose drive enable is 1 returns its drive value instead. Writes to word 2 have no effect.
- R4: Word 4 (byte 0x10) holds the styles of pins 0-7 and word 5 (byte 0x14) holds the styles of pins 8-15. Pin n's field is bits [3*(n%8)+2 : 3*(n%8)]. Bits 31:24 read as 0.
- R5: Style 0 (high) and style 1 (low) set the pin's pending bit on every cycle that the level holds, so clearing the bit while the level is still present has no lasting effect.
- R6: Style 2 (rising) and style 3 (falling) set the pending bit once per matching edge. The opposite edge and a held level do not set it again.
- R7: Style 4 sets the pending bit on both rising and falling edges.
- R8: Style codes 5, 6 and 7 never set a pending bit.
- R9: Word 3 (byte 0x0C) holds the pending bits. Writing 1 to a bit clears it and writing 0 leaves it as it is. If a detection falls in the same cycle as a clear, the bit stays set.
- R10: irq is 1 exactly while at least one pending bit is set.
- R11: Word 6 (byte 0x18) and word 7 (byte 0x1C) are 32-bit read/write storage and have no effect on the pads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe for one full-word write |
| csr_waddr | input | 3 | Word index (byte offset / 4) |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for the indexed word |
| pad_in | input | 16 | Raw pin levels |
| pad_out | output | 16 | Pin drive values |
| pad_oe | output | 16 | Pin drive enables |
| irq | output | 1 | Combined pending interrupt |

## Verification
The bound checker runs on every cycle. It checks that a detection always leaves its pending bit set and that a write-1 clear removes a bit when no detection competes with it. It also checks that codes 5-7 never produce a detection, that a rising or falling style cannot detect twice in a row, that irq only rises after a detection, and that the drive enables change only on a write to their word. Other behaviours need the bench's scenarios, because they depend on the stimulus history of a pin: synchroniser latency, read-back of driven pins, whether a level refires after a clear, field placement in the style words, and whether the storage words are independent.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int STY_W     = 3;
    localparam int PER_TYPE  = 8;
    localparam int WIDX_W    = 3;

    typedef enum logic [STY_W-1:0] {
        STY_HIGH = 3'd0,
        STY_LOW  = 3'd1,
        STY_RISE = 3'd2,
        STY_FALL = 3'd3,
        STY_BOTH = 3'd4
    } sty_e;

    localparam logic [WIDX_W-1:0] W_DOUT = 3'd0;
    localparam logic [WIDX_W-1:0] W_OE   = 3'd1;
    localparam logic [WIDX_W-1:0] W_PIN  = 3'd2;
    localparam logic [WIDX_W-1:0] W_PEND = 3'd3;
    localparam logic [WIDX_W-1:0] W_TYLO = 3'd4;
    localparam logic [WIDX_W-1:0] W_TYHI = 3'd5;
    localparam logic [WIDX_W-1:0] W_CKCF = 3'd6;
    localparam logic [WIDX_W-1:0] W_DBCF = 3'd7;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stab;
        logic [WIDTH-1:0] last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = raw;
        s_d.stab = s_q.meta;
        s_d.last = s_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur  = s_q.stab;
    assign prev = s_q.last;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]       cur,
    input  logic [WIDTH-1:0]       prev,
    input  logic [WIDTH*STY_W-1:0] styles,
    output logic [WIDTH-1:0]       evt
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic [STY_W-1:0] st;
        logic             hit;
        assign st = styles[STY_W*i +: STY_W];
        always_comb begin
            case (st)
                STY_HIGH: hit = cur[i];
                STY_LOW:  hit = !cur[i];
                STY_RISE: hit = cur[i] && !prev[i];
                STY_FALL: hit = !cur[i] && prev[i];
                STY_BOTH: hit = cur[i] ^ prev[i];
                default:  hit = 1'b0;
            endcase
        end
        assign evt[i] = hit;
    end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csr_we,
    input  logic [WIDX_W-1:0]   csr_waddr,
    input  logic [DATA_W-1:0]   csr_wdata,
    output logic [DATA_W-1:0]   csr_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);
    localparam int TYP_W = PER_TYPE * STY_W;

    typedef struct packed {
        logic [NUM_PINS-1:0] dout;
        logic [NUM_PINS-1:0] oe;
        logic [NUM_PINS-1:0] pend;
        logic [TYP_W-1:0]    tylo;
        logic [TYP_W-1:0]    tyhi;
        logic [DATA_W-1:0]   ckcf;
        logic [DATA_W-1:0]   dbcf;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_PINS-1:0]       pin_cur;
    logic [NUM_PINS-1:0]       pin_prev;
    logic [NUM_PINS-1:0]       evt;
    logic [NUM_PINS-1:0]       clr;
    logic [NUM_PINS-1:0]       pin_view;
    logic [2*TYP_W-1:0]        typ_all;
    logic [NUM_PINS*STY_W-1:0] style_flat;
    logic [NUM_PINS-1:0]       pend_q;

    gpio_pin_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (pad_in),
        .cur  (pin_cur),
        .prev (pin_prev)
    );

    assign typ_all    = {r_q.tyhi, r_q.tylo};
    assign style_flat = typ_all[NUM_PINS*STY_W-1:0];

    gpio_evt_detect #(.WIDTH(NUM_PINS)) u_det (
        .cur   (pin_cur),
        .prev  (pin_prev),
        .styles(style_flat),
        .evt   (evt)
    );

    always_comb begin
        r_d = r_q;
        clr = '0;
        if (csr_we) begin
            case (csr_waddr)
                W_DOUT:  r_d.dout = csr_wdata[NUM_PINS-1:0];
                W_OE:    r_d.oe   = csr_wdata[NUM_PINS-1:0];
                W_PEND:  clr      = csr_wdata[NUM_PINS-1:0];
                W_TYLO:  r_d.tylo = csr_wdata[TYP_W-1:0];
                W_TYHI:  r_d.tyhi = csr_wdata[TYP_W-1:0];
                W_CKCF:  r_d.ckcf = csr_wdata;
                W_DBCF:  r_d.dbcf = csr_wdata;
                default: ;
            endcase
        end
        r_d.pend = (r_q.pend & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pin_view = (r_q.dout & r_q.oe) | (pin_cur & ~r_q.oe);

    always_comb begin
        csr_rdata = '0;
        case (csr_waddr)
            W_DOUT:  csr_rdata[NUM_PINS-1:0] = r_q.dout;
            W_OE:    csr_rdata[NUM_PINS-1:0] = r_q.oe;
            W_PIN:   csr_rdata[NUM_PINS-1:0] = pin_view;
            W_PEND:  csr_rdata[NUM_PINS-1:0] = r_q.pend;
            W_TYLO:  csr_rdata[TYP_W-1:0]    = r_q.tylo;
            W_TYHI:  csr_rdata[TYP_W-1:0]    = r_q.tyhi;
            W_CKCF:  csr_rdata               = r_q.ckcf;
            default: csr_rdata               = r_q.dbcf;
        endcase
    end

    assign pend_q  = r_q.pend;
    assign pad_out = r_q.dout;
    assign pad_oe  = r_q.oe;
    assign irq     = |r_q.pend;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      csr_we,
    input logic [WIDX_W-1:0]         csr_waddr,
    input logic [NUM_PINS-1:0]       wbits,
    input logic [NUM_PINS-1:0]       pad_oe,
    input logic                      irq,
    input logic [NUM_PINS-1:0]       pend,
    input logic [NUM_PINS-1:0]       evt,
    input logic [NUM_PINS*STY_W-1:0] styles
);
    // R2: drive enables move only on a write to their word
    a_r2_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_we && csr_waddr == W_OE) |=> $stable(pad_oe));

    // R10: the combined line can only come up after a detection
    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(evt != '0));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic [STY_W-1:0] st;
        assign st = styles[STY_W*i +: STY_W];

        // R8: unused codes never detect
        a_r8_no_detect: assert property (@(posedge clk) disable iff (!rst_n)
            (st >= 3'd5) |-> !evt[i]);

        // R6: a single-edge style cannot detect on two cycles in a row
        a_r6_rise_once: assert property (@(posedge clk) disable iff (!rst_n)
            (st == STY_RISE && evt[i]) |=> !(st == STY_RISE && evt[i]));
        a_r6_fall_once: assert property (@(posedge clk) disable iff (!rst_n)
            (st == STY_FALL && evt[i]) |=> !(st == STY_FALL && evt[i]));

        // R9: a detection always leaves the bit set, even against a clear
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> pend[i]);

        // R9: an uncontested write-1 clears the bit
        a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_we && csr_waddr == W_PEND && wbits[i] && !evt[i]) |=> !pend[i]);
    end
endmodule

bind gpio_irq_unit gpio_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csr_we   (csr_we),
    .csr_waddr(csr_waddr),
    .wbits    (csr_wdata[NUM_PINS-1:0]),
    .pad_oe   (pad_oe),
    .irq      (irq),
    .pend     (pend_q),
    .evt      (evt),
    .styles   (style_flat)
);

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [2:0]  csr_waddr = 3'd0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [23:0] tshadow [2];

    always #2 clk = ~clk;

    gpio_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_waddr(csr_waddr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_waddr = w; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] w, output logic [31:0] v);
        @(negedge clk);
        csr_waddr = w;
        #1 v = csr_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic set_style(input int pin, input logic [2:0] code);
        int h = pin / 8;
        int sh = 3 * (pin % 8);
        tshadow[h] = (tshadow[h] & ~(24'h7 << sh)) | (24'(code) << sh);
        wr(3'(4 + h), {8'h0, tshadow[h]});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int w = 0; w < 8; w++) begin
            rd(3'(w), v);
            chk($sformatf("R1 reset word %0d", w), v, 32'h0);
        end
        chk("R1 reset pad_out", {16'h0, pad_out}, 32'h0);
        chk("R1 reset pad_oe", {16'h0, pad_oe}, 32'h0);
        chk("R1 reset irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_drive();
        logic [31:0] v;
        wr(3'd0, 32'hFFFF_A5C3);
        rd(3'd0, v);
        chk("R2 dout readback", v, 32'h0000_A5C3);
        chk("R2 pad_out", {16'h0, pad_out}, 32'h0000_A5C3);
        wr(3'd1, 32'h1234_00FF);
        rd(3'd1, v);
        chk("R2 oe readback", v, 32'h0000_00FF);
        chk("R2 pad_oe", {16'h0, pad_oe}, 32'h0000_00FF);
    endtask

    task automatic t_input();
        logic [31:0] v;
        @(negedge clk);
        pad_in = 16'h3CAA;
        settle();
        rd(3'd2, v);
        chk("R3 input with driven low byte", v, 32'h0000_3CC3);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v);
        chk("R3 input write ignored", v, 32'h0000_3CC3);
        wr(3'd1, 32'h0);
        rd(3'd2, v);
        chk("R3 input undriven", v, 32'h0000_3CAA);
        @(negedge clk);
        pad_in = 16'h0000;
        settle();
        wr(3'd3, 32'hFFFF);
        rd(3'd3, v);
        chk("R9 clear all after level hits", v, 32'h0);
        chk("R10 irq low when none pending", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, v);
        chk("R4 style word lo width", v, 32'h00FF_FFFF);
        wr(3'd5, 32'hA5A5_A5A5);
        rd(3'd5, v);
        chk("R4 style word hi width", v, 32'h00A5_A5A5);
        tshadow[0] = 24'hFFFFFF;
        tshadow[1] = 24'hFFFFFF;
        wr(3'd5, 32'h00FF_FFFF);
        wr(3'd3, 32'hFFFF);
        set_style(13, 3'd5);
        rd(3'd5, v);
        chk("R4 pin13 field at bits 17:15", v, 32'h00FE_FFFF & ~32'h0001_0000 | 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        set_style(3, 3'd0);
        @(negedge clk); pad_in[3] = 1'b1;
        settle();
        rd(3'd3, v);
        chk("R5 high level sets", v, 32'h0008);
        chk("R10 irq with pending", {31'h0, irq}, 32'h1);
        wr(3'd3, 32'h0008);
        rd(3'd3, v);
        chk("R5 R9 level refires over clear", v, 32'h0008);
        @(negedge clk); pad_in[3] = 1'b0;
        settle();
        wr(3'd3, 32'h0008);
        rd(3'd3, v);
        chk("R5 clears once level gone", v, 32'h0);
        set_style(3, 3'd7);
        set_style(9, 3'd1);
        settle();
        rd(3'd3, v);
        chk("R5 low level sets", v, 32'h0200);
        @(negedge clk); pad_in[9] = 1'b1;
        settle();
        wr(3'd3, 32'h0200);
        rd(3'd3, v);
        chk("R5 low level gone", v, 32'h0);
        set_style(9, 3'd7);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        set_style(4, 3'd2);
        @(negedge clk); pad_in[4] = 1'b1;
        settle();
        rd(3'd3, v);
        chk("R6 rising sets", v, 32'h0010);
        wr(3'd3, 32'h0010);
        settle();
        rd(3'd3, v);
        chk("R6 held high no refire", v, 32'h0);
        @(negedge clk); pad_in[4] = 1'b0;
        settle();
        rd(3'd3, v);
        chk("R6 falling ignored in rising style", v, 32'h0);
        set_style(4, 3'd7);
        @(negedge clk); pad_in[12] = 1'b1;
        settle();
        set_style(12, 3'd3);
        settle();
        rd(3'd3, v);
        chk("R6 fall style quiet while high", v, 32'h0);
        @(negedge clk); pad_in[12] = 1'b0;
        settle();
        rd(3'd3, v);
        chk("R6 falling sets", v, 32'h1000);
        wr(3'd3, 32'h1000);
        settle();
        rd(3'd3, v);
        chk("R6 held low no refire", v, 32'h0);
        set_style(12, 3'd7);
    endtask

    task automatic t_both();
        logic [31:0] v;
        set_style(6, 3'd4);
        @(negedge clk); pad_in[6] = 1'b1;
        settle();
        rd(3'd3, v);
        chk("R7 either-edge on rise", v, 32'h0040);
        wr(3'd3, 32'h0040);
        @(negedge clk); pad_in[6] = 1'b0;
        settle();
        rd(3'd3, v);
        chk("R7 either-edge on fall", v, 32'h0040);
        wr(3'd3, 32'h0040);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        set_style(0, 3'd5);
        set_style(1, 3'd6);
        set_style(15, 3'd7);
        @(negedge clk); pad_in = pad_in | 16'h8003;
        settle();
        @(negedge clk); pad_in = pad_in & ~16'h8003;
        settle();
        rd(3'd3, v);
        chk("R8 codes 5-7 silent", v, 32'h0);
        chk("R8 irq stays low", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        set_style(4, 3'd2);
        @(negedge clk); pad_in[4] = 1'b1; pad_in[6] = 1'b1;
        settle();
        rd(3'd3, v);
        chk("R9 two pending", v, 32'h0050);
        wr(3'd3, 32'h0010);
        rd(3'd3, v);
        chk("R9 zero bits untouched", v, 32'h0040);
        chk("R10 irq with one left", {31'h0, irq}, 32'h1);
        wr(3'd3, 32'h0040);
        rd(3'd3, v);
        chk("R9 last cleared", v, 32'h0);
        chk("R10 irq drops", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_store();
        logic [31:0] v;
        logic [15:0] po, pe;
        po = pad_out; pe = pad_oe;
        wr(3'd6, 32'hDEAD_BEEF);
        wr(3'd7, 32'h1234_5678);
        rd(3'd6, v);
        chk("R11 clock word", v, 32'hDEAD_BEEF);
        rd(3'd7, v);
        chk("R11 debounce word", v, 32'h1234_5678);
        chk("R11 pads untouched", {pad_oe, pad_out}, {pe, po});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_drive();
        t_input();
        t_fields();
        t_level();
        t_edge();
        t_both();
        t_disabled();
        t_w1c();
        t_store();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule